// File: doc/BRIEF.md
# Packed Lane Shift, Compare and Mask Unit

This block is a 64-bit packed-integer execution unit for a vector-in-scalar datapath. Each operation takes one 64-bit operand and a second 64-bit operand that carries either a second vector or a scalar shift count. It returns one 64-bit result. Three groups of work share one result register. The lane shifter moves two 32-bit lanes or four 16-bit lanes left, right with sign fill, or right with zero fill, and every lane moves by the same amount. The lane comparator tests four signed 16-bit lanes for greater-than or for equality and packs one bit per lane at the bottom of the result. The mask expander does the reverse of that packing: it turns four flag bits into four 16-bit lanes of all ones or all zeros. A compare followed by an expand therefore gives a lane-select mask.

Operations enter through a valid/ready input channel, and results leave through a valid/ready output channel. The unit holds one result at a time. A new operation is accepted when the result register is empty or when its current result is being taken in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` stays low and the pending result and `out_valid` do not change. The result of an accepted operation appears one cycle after the handshake.

Top module: `pk_lane_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R2: Opcodes 0, 1 and 2 shift the two 32-bit lanes (lane 0 = bits [31:0]) left, right with sign fill and right with zero fill respectively. The amount is the unsigned value of `in_src_b[7:0]`, shared by both lanes. Bits [63:8] of `in_src_b` have no effect.
- R3: Opcodes 3, 4 and 5 shift the four 16-bit lanes (lane 0 = bits [15:0]) left, right with sign fill and right with zero fill respectively, with the same shared amount as in R2.
- R4: A shift amount equal to or above the lane width (32 for opcodes 0-2, 16 for opcodes 3-5) saturates. Opcodes 1 and 4 fill the lane with its sign bit. The left and zero-fill shifts give zero.
- R5: Opcode 6 sets result bit i when signed 16-bit lane i of `in_src_a` is greater than lane i of `in_src_b`. Opcode 7 sets bit i when the two lanes are equal. Result bits [63:4] are zero.
- R6: Opcode 8 makes result lane i (bits [16i+15:16i]) 16'hFFFF when `in_src_a[i]` is 1 and 16'h0000 otherwise. `in_src_a[63:4]` and `in_src_b` have no effect.
- R7: Opcodes 9 to 15 give an all-zero result.
- R8: An operation accepted when `in_valid` and `in_ready` are both high at a clock edge sets `out_valid` and its result on `out_data` at that same edge, so the result is visible in the following cycle.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A result taken with no new operation accepted clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation on the input channel is valid |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 4 | Operation code (see R2-R7) |
| in_src_a | input | 64 | First packed operand |
| in_src_b | input | 64 | Second packed operand or shift amount in bits [7:0] |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Packed result |

## Verification
The assertions assume that the producer and consumer follow the handshake. The producer may change the opcode and operands freely between handshakes, and the consumer may drop `out_ready` in any cycle. The checker records the opcode of each accepted operation and infers from it which shape the pending result must have. This assumes that only accepted operations reach the result register. The stimulus covers that range: it presents operations in back-to-back cycles and with gaps, turns random back-pressure on and off, and sends shift amounts at the lane-width limits (15, 16, 31, 32) as well as above them. It also sets unused upper operand bits and uses opcodes outside the defined set.

// File: rtl/pk_lane_pkg.sv
package pk_lane_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned AMT_W  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_W  = 4'd0,
    OP_SRA_W  = 4'd1,
    OP_SRL_W  = 4'd2,
    OP_SHL_H  = 4'd3,
    OP_SRA_H  = 4'd4,
    OP_SRL_H  = 4'd5,
    OP_CMP_GT = 4'd6,
    OP_CMP_EQ = 4'd7,
    OP_EXPAND = 4'd8
  } lane_op_e;

  typedef enum logic [1:0] {
    SK_NONE  = 2'd0,
    SK_LEFT  = 2'd1,
    SK_ARITH = 2'd2,
    SK_LOGIC = 2'd3
  } shift_kind_e;

endpackage

// File: rtl/pk_lane_shift.sv
module pk_lane_shift
  import pk_lane_pkg::*;
#(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned AMT_BITS = 8
) (
  input  logic [WIDTH-1:0]    din,
  input  logic [AMT_BITS-1:0] amt,
  input  shift_kind_e         kind,
  output logic [WIDTH-1:0]    dout
);

  localparam int unsigned LANES = WIDTH / LANE_W;
  localparam int unsigned SH_W  = $clog2(LANE_W);

  logic            sat;
  logic [SH_W-1:0] sh;

  // One saturation decision shared by every lane.
  assign sat = (32'(amt) >= LANE_W);
  assign sh  = amt[SH_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] res;

    assign lane = din[i*LANE_W +: LANE_W];

    always_comb begin
      unique case (kind)
        SK_LEFT:  res = sat ? '0 : (lane << sh);
        SK_ARITH: res = sat ? {LANE_W{lane[LANE_W-1]}}
                            : LANE_W'($signed(lane) >>> sh);
        SK_LOGIC: res = sat ? '0 : (lane >> sh);
        default:  res = '0;
      endcase
    end

    assign dout[i*LANE_W +: LANE_W] = res;
  end

endmodule

// File: rtl/pk_lane_cmp.sv
module pk_lane_cmp #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned LANES = WIDTH / LANE_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [LANES-1:0] gt,
  output logic [LANES-1:0] eq
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [LANE_W-1:0] la;
    logic signed [LANE_W-1:0] lb;

    assign la    = a[i*LANE_W +: LANE_W];
    assign lb    = b[i*LANE_W +: LANE_W];
    assign gt[i] = (la > lb);
    assign eq[i] = (la == lb);
  end

endmodule

// File: rtl/pk_lane_expand.sv
module pk_lane_expand #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned LANES = WIDTH / LANE_W
) (
  input  logic [LANES-1:0] flags,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*LANE_W +: LANE_W] = {LANE_W{flags[i]}};
  end

endmodule

// File: rtl/pk_lane_unit.sv
module pk_lane_unit
  import pk_lane_pkg::*;
#(
  parameter int unsigned WIDTH    = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned AMT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_src_a,
  input  logic [WIDTH-1:0] in_src_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  localparam int unsigned HLANES = WIDTH / HALF_W;

  lane_op_e          op;
  shift_kind_e       kind_w;
  shift_kind_e       kind_h;
  logic [WIDTH-1:0]  shw_res;
  logic [WIDTH-1:0]  shh_res;
  logic [WIDTH-1:0]  exp_res;
  logic [HLANES-1:0] cmp_gt;
  logic [HLANES-1:0] cmp_eq;
  logic [WIDTH-1:0]  next_res;
  logic              accept;

  assign op = lane_op_e'(in_op);

  always_comb begin
    kind_w = SK_NONE;
    kind_h = SK_NONE;
    unique case (op)
      OP_SHL_W: kind_w = SK_LEFT;
      OP_SRA_W: kind_w = SK_ARITH;
      OP_SRL_W: kind_w = SK_LOGIC;
      OP_SHL_H: kind_h = SK_LEFT;
      OP_SRA_H: kind_h = SK_ARITH;
      OP_SRL_H: kind_h = SK_LOGIC;
      default: ;
    endcase
  end

  pk_lane_shift #(.WIDTH(WIDTH), .LANE_W(WORD_W), .AMT_BITS(AMT_BITS)) u_shift_w (
    .din  (in_src_a),
    .amt  (in_src_b[AMT_BITS-1:0]),
    .kind (kind_w),
    .dout (shw_res)
  );

  pk_lane_shift #(.WIDTH(WIDTH), .LANE_W(HALF_W), .AMT_BITS(AMT_BITS)) u_shift_h (
    .din  (in_src_a),
    .amt  (in_src_b[AMT_BITS-1:0]),
    .kind (kind_h),
    .dout (shh_res)
  );

  pk_lane_cmp #(.WIDTH(WIDTH), .LANE_W(HALF_W)) u_cmp (
    .a  (in_src_a),
    .b  (in_src_b),
    .gt (cmp_gt),
    .eq (cmp_eq)
  );

  pk_lane_expand #(.WIDTH(WIDTH), .LANE_W(HALF_W)) u_expand (
    .flags (in_src_a[HLANES-1:0]),
    .dout  (exp_res)
  );

  always_comb begin
    unique case (op)
      OP_SHL_W, OP_SRA_W, OP_SRL_W: next_res = shw_res;
      OP_SHL_H, OP_SRA_H, OP_SRL_H: next_res = shh_res;
      OP_CMP_GT: next_res = {{(WIDTH-HLANES){1'b0}}, cmp_gt};
      OP_CMP_EQ: next_res = {{(WIDTH-HLANES){1'b0}}, cmp_eq};
      OP_EXPAND: next_res = exp_res;
      default:   next_res = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= next_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pk_lane_unit_chk.sv
module pk_lane_unit_chk #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned HALF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data
);

  localparam int unsigned HLANES = WIDTH / HALF_W;

  logic [3:0] held_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_op <= '0;
    else if (in_valid && in_ready) held_op <= in_op;
  end

  function automatic logic lanes_are_masks(input logic [WIDTH-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < HLANES; i++) begin
      if (d[i*HALF_W +: HALF_W] != '0 && d[i*HALF_W +: HALF_W] != '1) ok = 1'b0;
    end
    return ok;
  endfunction

  // R5: packed compare results leave the upper bits clear
  p_cmp_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (held_op == 4'd6 || held_op == 4'd7)) |-> (out_data[WIDTH-1:HLANES] == '0));

  // R6: expanded lanes are whole masks
  p_expand_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && held_op == 4'd8) |-> lanes_are_masks(out_data));

  // R7: undefined opcodes give zero
  p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && held_op > 4'd8) |-> (out_data == '0));

  // R8: an accepted operation produces a result the next cycle
  p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: a stalled result holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: a stalled result blocks the input
  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: a drained result with no new work clears valid
  p_drain_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind pk_lane_unit pk_lane_unit_chk #(.WIDTH(WIDTH), .HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/pk_lane_unit_bench.sv
`timescale 1ns/1ps
module pk_lane_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [63:0] in_src_a = '0;
  logic [63:0] in_src_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int fails = 0;
  bit bp = 1'b0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pk_lane_unit u_pk_lane_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic [63:0] b);
    int amt = int'(b[7:0]);
    if (op <= 4'd2) return (amt >= 32) ? "R4" : "R2";
    if (op <= 4'd5) return (amt >= 16) ? "R4" : "R3";
    if (op <= 4'd7) return "R5";
    if (op == 4'd8) return "R6";
    return "R7";
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int amt = int'(b[7:0]);
    if (op <= 4'd5) begin
      int w = (op <= 4'd2) ? 32 : 16;
      int kind = op % 3;
      longint unsigned mask = (64'd1 << w) - 1;
      for (int i = 0; i < 64 / w; i++) begin
        longint unsigned v = (a >> (i * w)) & mask;
        longint unsigned s = (v >> (w - 1)) & 1;
        longint unsigned o;
        if (kind == 0)      o = (amt >= w) ? 0 : ((v << amt) & mask);
        else if (kind == 1) o = (amt >= w) ? (s != 0 ? mask : 0)
                                          : ((v >> amt) | (s != 0 ? (mask ^ (mask >> amt)) : 0));
        else                o = (amt >= w) ? 0 : (v >> amt);
        r = r | (64'(o) << (i * w));
      end
    end else if (op == 4'd6 || op == 4'd7) begin
      for (int i = 0; i < 4; i++) begin
        shortint x = shortint'(a[16*i +: 16]);
        shortint y = shortint'(b[16*i +: 16]);
        r[i] = (op == 4'd6) ? (x > y) : (x == y);
      end
    end else if (op == 4'd8) begin
      for (int i = 0; i < 4; i++) r[16*i +: 16] = a[i] ? 16'hFFFF : 16'h0000;
    end
    return r;
  endfunction

  // One clock: check outputs of the last edge, drive this cycle, track handshakes.
  task automatic tick(input bit v, input logic [3:0] op, input logic [63:0] a,
                      input logic [63:0] b, output bit acc);
    @(negedge clk);
    check(out_valid == (exp_q.size() != 0), "R8 out_valid", 64'(out_valid), 64'(exp_q.size() != 0));
    if (out_valid && exp_q.size() != 0)
      check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
    in_valid = v; in_op = op; in_src_a = a; in_src_b = b;
    out_ready = bp ? 1'($urandom_range(0, 1)) : 1'b1;
    #1;
    check(in_ready == (!out_valid || out_ready), "R9 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
    acc = in_valid && in_ready;
    if (out_valid && out_ready && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (acc) begin
      exp_q.push_back(model(op, a, b));
      tag_q.push_back(tag_of(op, b));
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
    bit acc;
    do tick(1'b1, op, a, b, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(1'b0, 4'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, acc);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(out_data == '0, "R1 out_data", out_data, 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    idle(2);

    // R2: 32-bit lane shifts, upper amount bits ignored
    issue(4'd0, 64'h8000_0001_1234_5678, 64'hFFFF_FFFF_FFFF_FF04);
    issue(4'd1, 64'h8000_0001_F234_5678, 64'h0000_0000_0000_001F);
    issue(4'd2, 64'h8000_0001_F234_5678, 64'hABCD_0000_0000_0007);
    issue(4'd1, 64'h7FFF_FFFF_8000_0000, 64'd0);
    // R3: 16-bit lane shifts
    issue(4'd3, 64'h8001_7FFF_1234_FFFF, 64'd15);
    issue(4'd4, 64'h8001_7FFF_1234_FFFF, 64'd3);
    issue(4'd5, 64'h8001_7FFF_1234_FFFF, 64'd9);
    // R4: saturation at and above the lane width
    issue(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32);
    issue(4'd1, 64'h8000_0000_7FFF_FFFF, 64'd32);
    issue(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd255);
    issue(4'd4, 64'h8000_7FFF_FFFF_0001, 64'd16);
    issue(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd200);
    issue(4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_012C);
    // R5: signed compares
    issue(4'd6, 64'h8000_0001_7FFF_FFFF, 64'h7FFF_0001_8000_0000);
    issue(4'd7, 64'h8000_0001_7FFF_FFFF, 64'h8000_0002_7FFF_FFFF);
    issue(4'd7, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444);
    // R6: expand, upper bits ignored
    issue(4'd8, 64'hFFFF_FFFF_FFFF_FFF5, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(4'd8, 64'h0000_0000_0000_000A, 64'd0);
    // R7: undefined opcodes
    issue(4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(4'd15, 64'h1234_5678_9ABC_DEF0, 64'd1);
    idle(3);

    // R8/R9: random traffic with back-pressure
    bp = 1'b1;
    for (int n = 0; n < 600; n++) begin
      logic [63:0] b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b[7:0] = 8'($urandom_range(0, 40));
      if ($urandom_range(0, 4) == 0) idle(1);
      issue(4'($urandom_range(0, 15)), {$urandom, $urandom}, b);
    end
    bp = 1'b0;
    idle(4);
    finish_run();
  end

endmodule